// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers sixty-four interrupt request lines into two banks of thirty-two and reduces them to one interrupt line for a processor. Each line is either edge-latched or level-sensitive. The choice is fixed per bit by a parameter and is present from reset. An edge-latched line records an event on its rising edge, and that event stays latched until software acknowledges it. A level-sensitive line contributes only while it is high, and an acknowledge cannot remove it.

Software reaches the banks through a 32-bit register port with a combinational read path. Each bank offers four registers: latched events, an enable mask, a write-one-to-clear acknowledge, and the sampled input levels. The bank index is the low twelve address bits minus 0x10, shifted right by four. The input lines are assigned to banks in reverse order: lines 0 to 31 go to bank 1 and lines 32 to 63 go to bank 0.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After reset, the event, mask and level registers of both banks read zero, and `cpu_irq` is low.
- R2: Bank 0 decodes at 0x10 and bank 1 at 0x20. Within a bank, sub-offset 0x0 reads the events, 0x4 reads and writes the mask, 0x8 is the write-only acknowledge, and 0xC reads the levels.
- R3: These accesses read zero and leave all state unchanged when written: the acknowledge offset, any unused sub-offset, and any address whose bank index is 2 or more (including addresses below 0x10, where the subtraction wraps).
- R4: Input line k appears in bank (1 - k/32) at bit k mod 32.
- R5: The level register shows each input as sampled at the previous clock edge.
- R6: On an edge-latched line, a rising edge (input high, previous sample low) sets the event bit. The bit stays set after the input falls.
- R7: A level-sensitive line never sets its event bit, but it drives the output while it is high and unmasked.
- R8: A bank's pending set is (events | levels & level_sensitive) & mask. `cpu_irq` is high exactly when either bank has a pending bit.
- R9: A write to the acknowledge register clears the event bits that are written as ones. It has no effect on level-sensitive lines.
- R10: An edge-latched line that stays high does not set its event again after that event is acknowledged.
- R11: If a rising edge and an acknowledge of the same bit fall in the same cycle, the event bit ends up set.
- R12: By default, bank 1 treats bits 20 to 28 (0x1FF00000) as level-sensitive, and bank 0 has no level-sensitive bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines 0..63 |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is an acknowledge that lands in the same clock cycle as a fresh rising edge on the bit it clears. This needs the write strobe and the input transition to be driven at the same falling edge. A directed step after the vector table arranges exactly that timing. A second awkward case is an edge line that stays high through its acknowledge. The vector table keeps line 33 asserted across the acknowledge write, then checks that the event register and `cpu_irq` both stay low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam logic [3:0] SUB_EVT  = 4'h0;
   localparam logic [3:0] SUB_MASK = 4'h4;
   localparam logic [3:0] SUB_ACK  = 4'h8;
   localparam logic [3:0] SUB_LVL  = 4'hC;
   localparam logic [11:0] WIN_BASE = 12'h010;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] sel,
   output logic                 hit,
   output logic [3:0]           sub
);
   import irqc_pkg::*;

   logic [11:0] rel;
   logic [7:0]  idx;

   initial begin
      if (ADDR_W < 12) $error("ADDR_W must cover the 12-bit window");
      if (NUM_BANKS < 1 || NUM_BANKS > 255) $error("NUM_BANKS out of range");
   end

   always_comb begin
      rel = addr[11:0] - WIN_BASE;
      idx = rel[11:4];
      sub = addr[3:0];
      hit = (int'(idx) < NUM_BANKS);
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign sel[b] = hit && (int'(idx) == b);
   end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int            W    = 32,
   parameter logic [W-1:0]  SENS = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_in,
   input  logic         sel,
   input  logic         we,
   input  logic [3:0]   sub,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic [W-1:0] mask_o,
   output logic         pend_any
);
   import irqc_pkg::*;

   logic [W-1:0] lvl_q, evt_q, mask_q, ack_clr, rise;

   initial begin
      if (W < 1 || W > 32) $error("bank width must be 1..32");
   end

   assign ack_clr = (sel && we && sub == SUB_ACK) ? wdata : '0;
   assign rise    = lvl_in & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         mask_q <= '0;
      end else begin
         lvl_q <= lvl_in;
         if (sel && we && sub == SUB_MASK) mask_q <= wdata;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (SENS[i]) begin : g_level
         assign evt_q[i] = 1'b0;
      end else begin : g_edge
         logic ev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ev <= 1'b0;
            else if (rise[i]) ev <= 1'b1;
            else if (ack_clr[i]) ev <= 1'b0;
         end
         assign evt_q[i] = ev;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (sub)
            SUB_EVT:  rdata = evt_q;
            SUB_MASK: rdata = mask_q;
            SUB_LVL:  rdata = lvl_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign mask_o   = mask_q;
   assign pend_any = |((evt_q | (lvl_q & SENS)) & mask_q);

   // edge captured even under a simultaneous acknowledge
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & ~SENS)) |=> ((evt_q & $past(rise & ~SENS)) == $past(rise & ~SENS)));

   // acknowledge touches only the bits written as one
   assert_ack_spares_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(evt_q & ~ack_clr)) == $past(evt_q & ~ack_clr)));

   // level-sensitive bits never show up as events
   assert_lvl_no_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_in & SENS) != 0 |=> ((rdata & SENS) == 0 || sub != SUB_EVT));
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl #(
   parameter int                          NUM_BANKS = 2,
   parameter int                          BANK_W    = 32,
   parameter int                          ADDR_W    = 12,
   parameter logic [NUM_BANKS*BANK_W-1:0] LVL_SENS  = {32'h1FF0_0000, 32'h0000_0000}
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_we,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   output logic                        cpu_irq
);
   localparam int TOTAL = NUM_BANKS * BANK_W;

   logic [NUM_BANKS-1:0] sel, pend;
   logic                 hit;
   logic [3:0]           sub;
   logic [BANK_W-1:0]    rd   [NUM_BANKS];
   logic [TOTAL-1:0]     mask_all;

   initial begin
      if (BANK_W != 32) $error("register port is 32 bits wide");
   end

   irqc_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .sel(sel), .hit(hit), .sub(sub));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqc_bank #(.W(BANK_W), .SENS(LVL_SENS[b*BANK_W +: BANK_W])) u_bank (
         .clk(clk), .rst_n(rst_n),
         .lvl_in(irq_in[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
         .sel(sel[b]), .we(bus_we), .sub(sub), .wdata(bus_wdata),
         .rdata(rd[b]), .mask_o(mask_all[b*BANK_W +: BANK_W]),
         .pend_any(pend[b]));
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= rd[b];
   end

   assign cpu_irq = |pend;

   // no interrupt can reach the CPU with every mask bit clear
   assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (|mask_all));

   // a decoded address selects at most one bank
   assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel) && (hit || sel == '0));

   // writes outside the banks leave the masks alone
   assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit) |=> $stable(mask_all));
endmodule

// File: tb/dual_bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_tb_top;
   localparam logic [1:0] OP_IN = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] addr;
      logic [63:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VECS [NV] = '{
      '{OP_RD,  12'h010, 64'h0, 32'h0, 4'd1},            // R1 events zero
      '{OP_RD,  12'h024, 64'h0, 32'h0, 4'd1},            // R1 mask zero
      '{OP_IRQ, 12'h000, 64'h0, 32'h0, 4'd1},            // R1 irq low
      '{OP_WR,  12'h024, 64'hFFFF_FFFF, 32'h0, 4'd2},
      '{OP_RD,  12'h024, 64'h0, 32'hFFFF_FFFF, 4'd2},    // R2 mask readback
      '{OP_IN,  12'h000, 64'h8, 32'h0, 4'd4},            // line 3
      '{OP_RD,  12'h02C, 64'h0, 32'h8, 4'd5},            // R5 level
      '{OP_RD,  12'h020, 64'h0, 32'h8, 4'd6},            // R6 event set
      '{OP_IRQ, 12'h000, 64'h0, 32'h1, 4'd8},            // R8
      '{OP_IN,  12'h000, 64'h0, 32'h0, 4'd6},
      '{OP_RD,  12'h020, 64'h0, 32'h8, 4'd6},            // R6 event held
      '{OP_RD,  12'h02C, 64'h0, 32'h0, 4'd5},
      '{OP_WR,  12'h028, 64'h8, 32'h0, 4'd9},
      '{OP_RD,  12'h020, 64'h0, 32'h0, 4'd9},            // R9 cleared
      '{OP_IRQ, 12'h000, 64'h0, 32'h0, 4'd9},
      '{OP_IN,  12'h000, 64'h0010_0000, 32'h0, 4'd7},    // line 20, level
      '{OP_RD,  12'h020, 64'h0, 32'h0, 4'd7},            // R7 no event
      '{OP_IRQ, 12'h000, 64'h0, 32'h1, 4'd7},
      '{OP_WR,  12'h028, 64'hFFFF_FFFF, 32'h0, 4'd9},
      '{OP_IRQ, 12'h000, 64'h0, 32'h1, 4'd9},            // R9 level survives ack
      '{OP_IN,  12'h000, 64'h0, 32'h0, 4'd7},
      '{OP_IRQ, 12'h000, 64'h0, 32'h0, 4'd7},
      '{OP_IN,  12'h000, 64'h2_0000_0000, 32'h0, 4'd4},  // line 33
      '{OP_RD,  12'h01C, 64'h0, 32'h2, 4'd4},            // R4 bank 0 bit 1
      '{OP_RD,  12'h010, 64'h0, 32'h2, 4'd6},
      '{OP_IRQ, 12'h000, 64'h0, 32'h0, 4'd8},            // R8 masked off
      '{OP_WR,  12'h014, 64'h2, 32'h0, 4'd8},
      '{OP_IRQ, 12'h000, 64'h0, 32'h1, 4'd8},
      '{OP_WR,  12'h018, 64'h2, 32'h0, 4'd10},           // ack, line held high
      '{OP_RD,  12'h010, 64'h0, 32'h0, 4'd10},           // R10 no relatch
      '{OP_IRQ, 12'h000, 64'h0, 32'h0, 4'd12},           // R12 bank 0 is edge
      '{OP_WR,  12'h030, 64'hFFFF_FFFF, 32'h0, 4'd3},
      '{OP_RD,  12'h030, 64'h0, 32'h0, 4'd3},            // R3 bank 2
      '{OP_RD,  12'h024, 64'h0, 32'hFFFF_FFFF, 4'd3},
      '{OP_WR,  12'h004, 64'h0, 32'h0, 4'd3},            // wraps below window
      '{OP_RD,  12'h014, 64'h0, 32'h2, 4'd3},
      '{OP_RD,  12'h028, 64'h0, 32'h0, 4'd3},            // R3 ack reads zero
      '{OP_WR,  12'h026, 64'h0, 32'h0, 4'd3},            // unused offset
      '{OP_RD,  12'h024, 64'h0, 32'hFFFF_FFFF, 4'd3},
      '{OP_RD,  12'h026, 64'h0, 32'h0, 4'd3},
      '{OP_IN,  12'h000, 64'h3008_0000, 32'h0, 4'd12},   // lines 19, 28, 29
      '{OP_RD,  12'h020, 64'h0, 32'h2008_0000, 4'd12},   // R12 bit 28 level
      '{OP_RD,  12'h02C, 64'h0, 32'h3008_0000, 4'd12},
      '{OP_RD,  12'h01C, 64'h0, 32'h0, 4'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dual_bank_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_irq(cpu_irq));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int req);
      bus_addr = a;
      #1;
      check(bus_rdata, exp, req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         case (VECS[v].op)
            OP_IN:  begin irq_in = VECS[v].data; @(negedge clk); end
            OP_WR:  wr(VECS[v].addr, VECS[v].data[31:0]);
            OP_RD:  rd(VECS[v].addr, VECS[v].exp, int'(VECS[v].req));
            default: begin #1; check({31'h0, cpu_irq}, VECS[v].exp, int'(VECS[v].req)); end
         endcase
      end

      // R11: rising edge on line 5 and its acknowledge in one cycle
      irq_in = 64'h3008_0000;
      bus_addr = 12'h028; bus_wdata = 32'h20; bus_we = 1'b1;
      irq_in[5] = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd(12'h020, 32'h2008_0020, 11);

      // R4: every line lands in its bank at its bit
      for (int k = 0; k < 64; k++) begin
         irq_in = 64'h1 << k;
         @(negedge clk);
         rd((k < 32) ? 12'h02C : 12'h01C, 32'h1 << (k % 32), 4);
         rd((k < 32) ? 12'h01C : 12'h02C, 32'h0, 4);
      end
      irq_in = '0;
      @(negedge clk);

      // R1: reset mid-run clears everything
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(12'h014, 32'h0, 1);
      rd(12'h024, 32'h0, 1);
      rd(12'h020, 32'h0, 1);
      rd(12'h010, 32'h0, 1);
      check({31'h0, cpu_irq}, 32'h0, 1);
      finish_run();
   end
endmodule